// File: doc/BRIEF.md
# Flag-Generating Integer Add/Subtract Unit

This unit performs one two's-complement add or subtract per clock on two W-bit operands. Four operations are selected by a 2-bit code: plain add, plain subtract, add including an incoming carry, and subtract including an incoming borrow. Along with the W-bit result it returns five status bits: carry (unsigned carry-out on add-type operations, unsigned borrow on subtract-type operations), signed overflow, sign, zero, and even parity of the low eight result bits.

Subtraction reuses the same adder. The second operand is inverted and the adder's carry-in is set, so one carry chain serves all four operations. Signed overflow is taken from the carries entering and leaving the top bit. The output stage is registered by default, which gives one cycle of latency. A parameter can remove that stage and make the unit purely combinational. The width W must be at least 8, so that the low-byte parity is defined.

Top module: `addsub_flag_unit`

## Requirements
- R1: Operation code 00 (add) gives result = (opa + opb) mod 2^W. Code 10 (add with carry) gives (opa + opb + cin_flag) mod 2^W.
- R2: Operation code 01 (subtract) gives result = (opa - opb) mod 2^W. Code 11 (subtract with borrow) gives (opa - opb - cin_flag) mod 2^W, with cin_flag acting as the borrow.
- R3: flag_ovf equals the XOR of the carry into the top bit and the carry out of it. Equivalently, it is 1 exactly when the result sign differs from the sign of opa while opa and the effective second operand share a sign. For subtract-type operations the effective second operand is the inverted opb.
- R4: For add-type operations, flag_carry is the unsigned carry out of the top bit. For subtract-type operations it is 1 when an unsigned borrow occurs, meaning opa < opb + borrow-in.
- R5: flag_sign equals the top bit of the result.
- R6: flag_zero is 1 exactly when all W result bits are 0.
- R7: flag_parity is 1 when result bits [7:0] contain an even number of ones, and 0 otherwise.
- R8: With the default registered output, result and flags reflect the inputs sampled at the previous rising edge. A synchronous active-high rst clears result and all flags to 0.
- R9: cin_flag has no effect on result or flags for plain add (00) and plain subtract (01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 add with carry, 11 subtract with borrow |
| opa | input | W | First operand (minuend for subtraction) |
| opb | input | W | Second operand (subtrahend for subtraction) |
| cin_flag | input | 1 | Incoming carry (add with carry) or borrow (subtract with borrow) |
| result | output | W | Sum or difference |
| flag_carry | output | 1 | Carry out on add-type operations, borrow on subtract-type operations |
| flag_ovf | output | 1 | Signed overflow |
| flag_sign | output | 1 | Top bit of the result |
| flag_zero | output | 1 | Result is all zeros |
| flag_parity | output | 1 | Even parity of result bits [7:0] |

## Verification
The assertions check four properties on every cycle against the inputs held from the previous edge:
- the arithmetic value of the result for all four operations;
- the sign-based overflow rule, which is independent of the carry-XOR form used in the datapath;
- the unsigned-compare meaning of carry and borrow for plain add and subtract;
- the zero and parity flags against population counts of the result.

Only the bench scenarios can show the remaining behaviour: the exact corner values at the signed and unsigned limits, that the incoming flag is ignored by plain add and subtract, the one-cycle latency, and the synchronous clearing by reset. The bench also compares the carry-XOR and sign-rule forms of overflow against each other across a random sweep.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_ADC = 2'b10,
    OP_SBB = 2'b11
  } op_e;

  typedef struct packed {
    logic carry;
    logic ovf;
    logic sign;
    logic zero;
    logic parity;
  } flags_t;

  localparam int PARITY_BITS = 8;
endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] opb,
  input  logic         cin_flag,
  output logic [W-1:0] b_eff,
  output logic         cin,
  output logic         is_sub
);
  // Subtract-type codes have bit 0 set; they invert the second operand
  assign is_sub = op[0];
  assign b_eff  = is_sub ? ~opb : opb;

  always_comb begin
    unique case (op)
      OP_ADD:  cin = 1'b0;
      OP_SUB:  cin = 1'b1;
      OP_ADC:  cin = cin_flag;
      OP_SBB:  cin = ~cin_flag;  // borrow-in becomes inverted carry-in
      default: cin = 1'b0;
    endcase
  end
endmodule

// File: rtl/addsub_adder_core.sv
module addsub_adder_core #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_msb_in,
  output logic         c_out
);
  localparam int LW = W - 1;

  logic [LW-1:0] low_sum;
  logic          msb_sum;

  // Lower bits first so the carry entering the sign bit is visible
  assign {c_msb_in, low_sum} = {1'b0, a[LW-1:0]} + {1'b0, b[LW-1:0]}
                             + {{LW{1'b0}}, cin};
  assign {c_out, msb_sum}    = {1'b0, a[W-1]} + {1'b0, b[W-1]} + {1'b0, c_msb_in};
  assign sum                 = {msb_sum, low_sum};
endmodule

// File: rtl/addsub_flag_gen.sv
module addsub_flag_gen
  import addsub_pkg::*;
#(
  parameter int W  = 8,
  parameter int PW = PARITY_BITS
) (
  input  logic [W-1:0] sum,
  input  logic         c_msb_in,
  input  logic         c_out,
  input  logic         is_sub,
  output flags_t       flags
);
  always_comb begin
    flags.carry  = c_out ^ is_sub;        // borrow polarity on subtraction
    flags.ovf    = c_msb_in ^ c_out;
    flags.sign   = sum[W-1];
    flags.zero   = ~|sum;
    flags.parity = ~^sum[PW-1:0];
  end
endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
  import addsub_pkg::*;
#(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin_flag,
  output logic [W-1:0] result,
  output logic         flag_carry,
  output logic         flag_ovf,
  output logic         flag_sign,
  output logic         flag_zero,
  output logic         flag_parity
);
  op_e          op;
  logic [W-1:0] b_eff;
  logic         add_cin;
  logic         is_sub;
  logic [W-1:0] sum;
  logic         c_msb_in;
  logic         c_out;
  flags_t       flags_d;
  logic [W-1:0] res_q;
  flags_t       flags_q;

  assign op = op_e'(op_sel);

  addsub_operand_prep #(.W(W)) prep_i (
    .op(op), .opb(opb), .cin_flag(cin_flag),
    .b_eff(b_eff), .cin(add_cin), .is_sub(is_sub)
  );

  addsub_adder_core #(.W(W)) core_i (
    .a(opa), .b(b_eff), .cin(add_cin),
    .sum(sum), .c_msb_in(c_msb_in), .c_out(c_out)
  );

  addsub_flag_gen #(.W(W)) flg_i (
    .sum(sum), .c_msb_in(c_msb_in), .c_out(c_out), .is_sub(is_sub),
    .flags(flags_d)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          res_q   <= '0;
          flags_q <= '0;
        end else begin
          res_q   <= sum;
          flags_q <= flags_d;
        end
      end
    end else begin : g_comb
      assign res_q   = sum;
      assign flags_q = flags_d;
    end
  endgenerate

  assign result      = res_q;
  assign flag_carry  = flags_q.carry;
  assign flag_ovf    = flags_q.ovf;
  assign flag_sign   = flags_q.sign;
  assign flag_zero   = flags_q.zero;
  assign flag_parity = flags_q.parity;
endmodule

// File: rtl/addsub_flag_unit_chk.sv
module addsub_flag_unit_chk #(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   op_sel,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         cin_flag,
  input logic [W-1:0] result,
  input logic         flag_carry,
  input logic         flag_ovf,
  input logic         flag_sign,
  input logic         flag_zero,
  input logic         flag_parity
);
  generate
    if (OUT_REG) begin : g_chk
      logic         chk_valid = 1'b0;
      logic [1:0]   p_op;
      logic [W-1:0] p_a;
      logic [W-1:0] p_b;
      logic         p_cin;
      logic [W-1:0] exp_res;
      logic [W-1:0] p_beff;
      logic [W:0]   ext_sum;

      always_ff @(posedge clk) begin
        chk_valid <= !rst;
        p_op      <= op_sel;
        p_a       <= opa;
        p_b       <= opb;
        p_cin     <= cin_flag;
      end

      always_comb begin
        unique case (p_op)
          2'b00:   exp_res = p_a + p_b;
          2'b01:   exp_res = p_a - p_b;
          2'b10:   exp_res = p_a + p_b + {{(W-1){1'b0}}, p_cin};
          default: exp_res = p_a - p_b - {{(W-1){1'b0}}, p_cin};
        endcase
        p_beff  = p_op[0] ? ~p_b : p_b;
        ext_sum = {1'b0, p_a} + {1'b0, p_b};
      end

      assert_result_value_R1_R2: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> result == exp_res);

      assert_ovf_sign_rule_R3: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> flag_ovf == ((p_a[W-1] == p_beff[W-1]) && (result[W-1] != p_a[W-1])));

      assert_add_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && p_op == 2'b00) |-> flag_carry == ext_sum[W]);

      assert_sub_borrow_R4: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && p_op == 2'b01) |-> flag_carry == (p_a < p_b));

      assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> flag_zero == ($countones(result) == 0));

      assert_parity_flag_R7: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> flag_parity == ($countones(result[7:0]) % 2 == 0));

      assert_sign_flag_R5: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> flag_sign == ($signed(exp_res) < 0));
    end
  endgenerate
endmodule

bind addsub_flag_unit addsub_flag_unit_chk #(.W(W), .OUT_REG(OUT_REG)) chk_i (
  .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb), .cin_flag(cin_flag),
  .result(result), .flag_carry(flag_carry), .flag_ovf(flag_ovf), .flag_sign(flag_sign),
  .flag_zero(flag_zero), .flag_parity(flag_parity)
);

// File: tb/addsub_flag_unit_tb_top.sv
module addsub_flag_unit_tb_top;
  localparam int W     = 8;
  localparam int NVEC  = 18;
  localparam int NRAND = 300;

  // {op[1:0], cin, a[7:0], b[7:0], res[7:0], C V S Z P}
  localparam logic [31:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 8'h80, 8'h80, 8'h00, 5'b11011},
    {2'b00, 1'b0, 8'h7F, 8'h01, 8'h80, 5'b01100},
    {2'b00, 1'b0, 8'hFF, 8'h01, 8'h00, 5'b10011},
    {2'b00, 1'b0, 8'h05, 8'hFD, 8'h02, 5'b10000},
    {2'b00, 1'b1, 8'h05, 8'hFD, 8'h02, 5'b10000},
    {2'b01, 1'b0, 8'h64, 8'h9C, 8'hC8, 5'b11100},
    {2'b01, 1'b0, 8'h64, 8'h32, 8'h32, 5'b00000},
    {2'b01, 1'b1, 8'h64, 8'h32, 8'h32, 5'b00000},
    {2'b01, 1'b0, 8'h80, 8'h01, 8'h7F, 5'b01000},
    {2'b01, 1'b0, 8'h05, 8'h05, 8'h00, 5'b00011},
    {2'b10, 1'b1, 8'h7E, 8'h01, 8'h80, 5'b01100},
    {2'b10, 1'b1, 8'hFF, 8'h00, 8'h00, 5'b10011},
    {2'b10, 1'b0, 8'h10, 8'h20, 8'h30, 5'b00001},
    {2'b11, 1'b1, 8'h00, 8'h00, 8'hFF, 5'b10101},
    {2'b11, 1'b1, 8'h80, 8'h00, 8'h7F, 5'b01000},
    {2'b11, 1'b0, 8'h50, 8'h20, 8'h30, 5'b00001},
    {2'b01, 1'b0, 8'h00, 8'h01, 8'hFF, 5'b10101},
    {2'b10, 1'b0, 8'h80, 8'hFF, 8'h7F, 5'b11000}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   op_sel = 2'b00;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         cin_flag = 1'b0;
  logic [W-1:0] result;
  logic         flag_carry, flag_ovf, flag_sign, flag_zero, flag_parity;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  addsub_flag_unit #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb), .cin_flag(cin_flag),
    .result(result), .flag_carry(flag_carry), .flag_ovf(flag_ovf), .flag_sign(flag_sign),
    .flag_zero(flag_zero), .flag_parity(flag_parity)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference from the requirements, integer arithmetic: {res, C, V, S, Z, P}
  function automatic logic [12:0] model(input logic [1:0] op, input logic ci,
                                        input logic [7:0] a, input logic [7:0] b);
    int sa, sb, sres, ures;
    logic c, v, v2, cmsb, cout;
    logic [7:0] r, beff;
    int cadd;
    sa = $signed(a);
    sb = $signed(b);
    cadd = (op[1] ? int'(ci) : 0);
    if (!op[0]) begin
      ures = int'(a) + int'(b) + cadd;
      sres = sa + sb + cadd;
      c    = (ures > 255);
    end else begin
      ures = int'(a) - int'(b) - cadd;
      sres = sa - sb - cadd;
      c    = (ures < 0);
    end
    r = ures[7:0];
    v = (sres > 127) || (sres < -128);
    // carry-XOR form, must agree with the range form (R3)
    beff = op[0] ? ~b : b;
    cmsb = ((int'(a[6:0]) + int'(beff[6:0]) + (op[0] ? 1 - cadd : cadd)) > 127);
    cout = ((int'(a) + int'(beff) + (op[0] ? 1 - cadd : cadd)) > 255);
    v2   = cmsb ^ cout;
    n_checks++;
    if (v != v2) begin
      n_fail++;
      $display("FAIL R3 model carry-xor actual=%0d expected=%0d", v2, v);
    end
    return {r, c, v, r[7], (r == 8'h00), ~^r};
  endfunction

  task automatic apply(input logic [1:0] op, input logic ci,
                       input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    op_sel = op; cin_flag = ci; opa = a; opb = b;
    @(posedge clk);
    #2;
  endtask

  task automatic check_all(input logic [7:0] er, input logic [4:0] ef, input string tag);
    check(result == er, {tag, " R1/R2 result"}, 32'(result), 32'(er));
    check(flag_carry == ef[4], {tag, " R4 carry"}, 32'(flag_carry), 32'(ef[4]));
    check(flag_ovf == ef[3], {tag, " R3 overflow"}, 32'(flag_ovf), 32'(ef[3]));
    check(flag_sign == ef[2], {tag, " R5 sign"}, 32'(flag_sign), 32'(ef[2]));
    check(flag_zero == ef[1], {tag, " R6 zero"}, 32'(flag_zero), 32'(ef[1]));
    check(flag_parity == ef[0], {tag, " R7 parity"}, 32'(flag_parity), 32'(ef[0]));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [12:0] m;
    // R8: reset clears outputs even with live inputs
    op_sel = 2'b00; opa = 8'h7F; opb = 8'h01; cin_flag = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check({result, flag_carry, flag_ovf, flag_sign, flag_zero, flag_parity} == '0,
          "R8 reset state", 32'({result, flag_carry, flag_ovf, flag_sign, flag_zero,
          flag_parity}), 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // Vector table: R1-R7, R9 entries 4 and 7
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][31:30], VEC[i][29], VEC[i][28:21], VEC[i][20:13]);
      check_all(VEC[i][12:5], VEC[i][4:0], $sformatf("vec%0d", i));
    end

    // R9: ADD/SUB outputs identical for both values of cin_flag
    for (int k = 0; k < 20; k++) begin
      logic [7:0] a, b;
      logic [1:0] op;
      logic [12:0] r0;
      a = 8'($urandom); b = 8'($urandom); op = {1'b0, 1'($urandom)};
      apply(op, 1'b0, a, b);
      r0 = {result, flag_carry, flag_ovf, flag_sign, flag_zero, flag_parity};
      apply(op, 1'b1, a, b);
      check({result, flag_carry, flag_ovf, flag_sign, flag_zero, flag_parity} == r0,
            "R9 cin ignored", 32'({result, flag_carry, flag_ovf, flag_sign, flag_zero,
            flag_parity}), 32'(r0));
    end

    // Random sweep against the reference model
    for (int k = 0; k < NRAND; k++) begin
      logic [7:0] a, b;
      logic [1:0] op;
      logic ci;
      a = 8'($urandom); b = 8'($urandom); op = 2'($urandom); ci = 1'($urandom);
      m = model(op, ci, a, b);
      apply(op, ci, a, b);
      check_all(m[12:5], m[4:0], $sformatf("rand%0d", k));
    end

    // R8: one-cycle latency, output holds until the next edge
    apply(2'b00, 1'b0, 8'h01, 8'h01);
    @(negedge clk);
    op_sel = 2'b00; opa = 8'h10; opb = 8'h10;
    #1;
    check(result == 8'h02, "R8 latency hold", 32'(result), 32'h02);
    @(posedge clk);
    #2;
    check(result == 8'h20, "R8 latency update", 32'(result), 32'h20);

    // R8: synchronous reset mid-stream
    @(negedge clk);
    rst = 1'b1;
    #1;
    check(result == 8'h20, "R8 reset synchronous", 32'(result), 32'h20);
    @(posedge clk);
    #2;
    check({result, flag_carry, flag_ovf, flag_sign, flag_zero, flag_parity} == '0,
          "R8 reset clears", 32'({result, flag_carry, flag_ovf, flag_sign, flag_zero,
          flag_parity}), 32'h0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule